// File: doc/BRIEF.md
# GPIO Port Register Bank

A sixteen-pin general-purpose I/O port exposed through a 32-bit word-addressed register bus (address, write enable, write data, read data). It stores per-pin mode, driver type, slew speed, pull selection, output level, a lock image, alternate-function selects and analog control. Only mode, driver type, pull and output level leave the block: they go to an external pin resolver, which hands back the resolved input levels. These levels can be read back through the bus.

Output levels can be changed in three ways. A plain write replaces the whole output word. An atomic write carries clear requests in its upper half and set requests in its lower half. A clear-only write carries clear requests alone. After every write that could change how a pin is resolved, a single-cycle strobe tells the resolver to evaluate again. The speed, lock, alternate-function and analog words are storage only and have no effect on behaviour.

Top module: `gpio_port_regs`

## Requirements
- R1: The word offsets are: 0x00 mode, 0x04 driver type, 0x08 speed, 0x0C pull, 0x10 input (read-only), 0x14 output, 0x18 atomic set/clear, 0x1C lock, 0x20 alt-function low, 0x24 alt-function high, 0x28 clear-only, 0x2C analog. Writes take effect at the clock edge. Reads are combinational from the address.
- R2: After reset, mode, speed and pull hold the parameter values MODE_INIT, SPEED_INIT and PULL_INIT. Every other stored word reads zero.
- R3: The mode, speed, pull and alt-function words store all 32 bits. The driver-type, output, lock and analog words store only bits 15:0, and bits 31:16 read as zero.
- R4: An atomic write clears each output bit whose request is present in bits 31:16. It then sets each output bit whose request is present in bits 15:0. A pin with both requests ends up at 1.
- R5: A clear-only write clears the output bits given in bits 15:0. Bits 31:16 of that write are ignored.
- R6: The atomic and clear-only offsets always read zero. A write to the input offset changes no stored state.
- R7: Reading the input offset returns the resolver's 16-bit value in bits 15:0, with bits 31:16 zero.
- R8: An offset that is unmapped or not word-aligned reads zero. A write to it changes no stored word.
- R9: `cfg_changed` is high for exactly the one cycle after a write to the mode, driver-type, pull, output, atomic or clear-only offset. It stays low after any other write.
- R10: The exported vectors always equal the stored mode, driver-type, pull and output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| pin_in | input | 16 | Resolved pin levels from the resolver |
| mode_o | output | 32 | Two-bit mode per pin (01 = output) |
| otype_o | output | 16 | Driver type per pin (1 = open-drain) |
| pull_o | output | 32 | Two-bit pull per pin |
| odata_o | output | 16 | Output level per pin |
| cfg_changed | output | 1 | One-cycle re-evaluate strobe |

## Verification
Two interactions can fall in one cycle.

The first is a clear request and a set request for the same pin inside one atomic write. The bench provokes this with patterns that overlap both partially and completely. It judges the result against a model that clears first and sets afterwards.

The second is the strobe from one write against a new write in the following cycle. Back-to-back writes mix triggering and non-triggering offsets, and the strobe is compared on every clock against the model's record of the previous cycle's write.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter logic [31:0] MODE_INIT  = 32'hFFFF_FFFF,
  parameter logic [31:0] SPEED_INIT = 32'h0000_0000,
  parameter logic [31:0] PULL_INIT  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [15:0] pin_in,
  output logic [31:0] mode_o,
  output logic [15:0] otype_o,
  output logic [31:0] pull_o,
  output logic [15:0] odata_o,
  output logic        cfg_changed
);
  logic [31:0] mode_q, speed_q, pull_q, afl_q, afh_q;
  logic [15:0] otype_q, out_q, lock_q, ana_q;
  logic        strobe_q;

  wire aligned = addr[1:0] == 2'b00;
  wire [3:0] idx = addr[5:2];
  wire we = wr_en && aligned;
  wire hits_cfg = we && (idx == 4'd0 || idx == 4'd1 || idx == 4'd3 ||
                         idx == 4'd5 || idx == 4'd6 || idx == 4'd10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT; speed_q <= SPEED_INIT; pull_q <= PULL_INIT;
      afl_q <= '0; afh_q <= '0;
      otype_q <= '0; out_q <= '0; lock_q <= '0; ana_q <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= hits_cfg;
      if (we) begin
        case (idx)
          4'd0:  mode_q  <= wdata;
          4'd1:  otype_q <= wdata[15:0];
          4'd2:  speed_q <= wdata;
          4'd3:  pull_q  <= wdata;
          4'd5:  out_q   <= wdata[15:0];
          4'd6:  out_q   <= (out_q & ~wdata[31:16]) | wdata[15:0];
          4'd7:  lock_q  <= wdata[15:0];
          4'd8:  afl_q   <= wdata;
          4'd9:  afh_q   <= wdata;
          4'd10: out_q   <= out_q & ~wdata[15:0];
          4'd11: ana_q   <= wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (idx)
        4'd0:  rdata = mode_q;
        4'd1:  rdata = {16'h0, otype_q};
        4'd2:  rdata = speed_q;
        4'd3:  rdata = pull_q;
        4'd4:  rdata = {16'h0, pin_in};
        4'd5:  rdata = {16'h0, out_q};
        4'd7:  rdata = {16'h0, lock_q};
        4'd8:  rdata = afl_q;
        4'd9:  rdata = afh_q;
        4'd11: rdata = {16'h0, ana_q};
        default: rdata = '0;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign otype_o = otype_q;
  assign pull_o = pull_q;
  assign odata_o = out_q;
  assign cfg_changed = strobe_q;

  // R4
  atomic_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 6'h18) |=> ((odata_o & $past(wdata[15:0])) == $past(wdata[15:0])));
  // R4
  atomic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 6'h18) |=> ((odata_o & $past(wdata[31:16] & ~wdata[15:0])) == 16'h0));
  // R5
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 6'h28) |=> ((odata_o & $past(wdata[15:0])) == 16'h0));
  // R9
  strobe_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 6'h00 || addr == 6'h14)) |=> cfg_changed);
  // R9
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !cfg_changed);
  // R8
  unmapped_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] != 2'b00) |=> $stable(odata_o));
  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 6'h18 || addr == 6'h28) |-> rdata == 32'h0);
endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  localparam logic [31:0] MI = 32'hABFF_FF00;
  localparam logic [31:0] SI = 32'h0000_00C0;
  localparam logic [31:0] PI = 32'h1234_5678;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata, mode_o, pull_o;
  logic [15:0] pin_in = 16'h5A5A, otype_o, odata_o;
  logic cfg_changed;

  gpio_port_regs #(.MODE_INIT(MI), .SPEED_INIT(SI), .PULL_INIT(PI)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .mode_o(mode_o), .otype_o(otype_o),
    .pull_o(pull_o), .odata_o(odata_o), .cfg_changed(cfg_changed));

  always #4 clk = ~clk;

  int vectors = 0, errs = 0;
  logic [31:0] m[12];
  logic exp_strobe;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [5:0] a);
    if (a[1:0] != 0) return 0;
    case (a[5:2])
      4: return {16'h0, pin_in};
      6, 10: return 0;
      12, 13, 14, 15: return 0;
      default: return m[a[5:2]];
    endcase
  endfunction

  task automatic model_reset();
    foreach (m[i]) m[i] = 0;
    m[0] = MI; m[2] = SI; m[3] = PI;
    exp_strobe = 0;
  endtask

  task automatic model_wr(logic [5:0] a, logic [31:0] d);
    int k = a[5:2];
    exp_strobe = 0;
    if (a[1:0] != 0) return;
    if (k == 0 || k == 1 || k == 3 || k == 5 || k == 6 || k == 10) exp_strobe = 1;
    if (k == 0 || k == 2 || k == 3 || k == 8 || k == 9) m[k] = d;
    else if (k == 1 || k == 5 || k == 7 || k == 11) m[k] = {16'h0, d[15:0]};
    else if (k == 6) m[5] = {16'h0, (m[5][15:0] & ~d[31:16]) | d[15:0]};
    else if (k == 10) m[5] = {16'h0, m[5][15:0] & ~d[15:0]};
  endtask

  task automatic compare_all(string req);
    chk({req, "/R10 mode"}, mode_o, m[0]);
    chk({req, "/R10 otype"}, {16'h0, otype_o}, m[1]);
    chk({req, "/R10 pull"}, pull_o, m[3]);
    chk({req, "/R10 out"}, {16'h0, odata_o}, m[5]);
    chk({req, "/R9 strobe"}, {31'h0, cfg_changed}, {31'h0, exp_strobe});
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 64; a += 4) begin
      addr = a[5:0]; #1;
      chk({req, " read"}, rdata, model_rd(a[5:0]));
    end
    addr = 6'h02; #1; chk("R8 unaligned read", rdata, 32'h0);
  endtask

  task automatic wr(string req, logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); model_wr(a, d);
    #2; wr_en = 0;
    compare_all(req);
  endtask

  task automatic idle();
    @(posedge clk); exp_strobe = 0; #2; compare_all("R9 idle");
  endtask

  initial begin
    #200000; errs++; $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs); $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    compare_all("R2");
    read_all("R2");
    // R1 R3: full and half words
    wr("R1", 6'h00, 32'h5555_AAAA);
    wr("R3", 6'h04, 32'hFFFF_00F0);
    wr("R3", 6'h08, 32'hDEAD_BEEF);
    wr("R1", 6'h0C, 32'hCAFE_F00D);
    wr("R3", 6'h14, 32'h1234_8001);
    wr("R3", 6'h1C, 32'hFFFF_FFFF);
    wr("R1", 6'h20, 32'h0102_0304);
    wr("R1", 6'h24, 32'hA0B0_C0D0);
    wr("R3", 6'h2C, 32'h8765_4321);
    read_all("R1/R3");
    // R4: overlapping set and clear
    wr("R4", 6'h14, 32'h0000_FFFF);
    wr("R4", 6'h18, 32'h00FF_0F00);
    wr("R4", 6'h18, 32'hFFFF_FFFF);
    wr("R4", 6'h18, 32'hFFFF_0000);
    wr("R4", 6'h18, 32'h0000_00A5);
    // R5
    wr("R5", 6'h28, 32'hFFFF_0001);
    wr("R5", 6'h28, 32'h0000_0080);
    // R6 R7
    wr("R6", 6'h10, 32'hFFFF_FFFF);
    pin_in = 16'hC3E1;
    read_all("R6/R7");
    // R8
    wr("R8", 6'h15, 32'hFFFF_FFFF);
    wr("R8", 6'h30, 32'hFFFF_FFFF);
    wr("R8", 6'h3C, 32'hFFFF_FFFF);
    read_all("R8");
    idle();
    // R9: back-to-back mix
    wr("R9", 6'h1C, 32'h1);
    wr("R9", 6'h0C, 32'h2);
    wr("R9", 6'h24, 32'h3);
    wr("R9", 6'h28, 32'h4);
    idle();
    idle();
    for (int i = 0; i < 40; i++) begin
      logic [5:0] a = 6'((i * 4 + (i % 7 == 0 ? 1 : 0)) % 48);
      wr("R4/R9 sweep", a, 32'h9E37_79B9 * (i + 1));
    end
    read_all("sweep");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule